// File: doc/BRIEF.md
# Iterative Back-Projection Image Reconstruction Controller

This block rebuilds a square conductive-distribution image (256 pixels by default) from a short vector of normalized capacitance readings (6 by default). It keeps the image in its own register store, which can be read from outside, and it orders the arithmetic of an iterative linear back-projection loop. The matrix-vector products are not computed here. They are delegated to an external multiply engine that holds the constant sensitivity matrix. The controller sends that engine one request per phase. In transpose mode it supplies a measurement-sized vector, and the engine returns one projected value per pixel. In forward mode the engine reads the current image through the image read port and returns one estimated reading per measurement.

A run begins with a start pulse, which captures the readings, the relaxation factor, the update limit and the residual threshold. The controller first builds an initial image from the back-projected readings. It then alternates forward estimates with relaxation-scaled error back-projections and subtractive pixel updates. The run stops when the largest absolute residual is at or below the threshold, or when the programmed number of updates has been performed. The done flag then rises and stays high. All values are signed fixed point with FRAC fractional bits, so 1.0 is 2^FRAC.

Top module: `ibp_recon_ctrl`

## Requirements
- R1: An accepted start captures meas_i, alpha_i, iter_limit_i and thresh_i. The first engine request has mvm_fwd_o=0 and presents the captured readings on mvm_vec_o, with element i at bits [i*DW +: DW]. Each returned value r, delivered with its pixel index, becomes pixel = sat(r).
- R2: After the initial image and after every update, the next request has mvm_fwd_o=1. For each returned estimate e with index i below NMEAS, the controller forms d_i = e - meas_i, wrapping at DW bits, and tracks the largest |d_i|.
- R3: When all estimates have been returned and that largest |d_i| (unsigned) is at or below the threshold, the run ends without another update.
- R4: Otherwise, when the number of updates already performed equals iter_limit_i, the run ends. A limit of 0 yields the initial image after a single forward estimate.
- R5: Otherwise a request with mvm_fwd_o=0 presents the differences d_i on mvm_vec_o. Each returned value r for pixel p gives pixel_p = sat(pixel_p - ((alpha*r) >>> FRAC)), computed at 2*DW bits.
- R6: sat() clamps every written pixel to the range 0 to 2^FRAC.
- R7: mvm_start_o is a one-cycle pulse. A new request is never issued until mvm_done_i has answered the previous one. A run that performs k updates issues exactly 2k+2 requests.
- R8: A start pulse during a run is ignored. Neither the run nor its captured inputs change.
- R9: done_o rises when a run ends and stays high until the next start. It falls one cycle after that start is accepted.
- R10: After reset, done_o and mvm_start_o are low and every pixel reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a reconstruction run |
| meas_i | input | NMEAS*DW | Normalized readings, element i at [i*DW +: DW] |
| alpha_i | input | DW | Relaxation factor, signed fixed point |
| iter_limit_i | input | ITW | Maximum number of image updates |
| thresh_i | input | DW | Residual threshold, unsigned |
| done_o | output | 1 | Run finished, held until the next start |
| mvm_start_o | output | 1 | Engine request pulse |
| mvm_fwd_o | output | 1 | 1: forward estimate, 0: transpose projection |
| mvm_vec_o | output | NMEAS*DW | Vector operand for transpose requests |
| mvm_res_valid_i | input | 1 | Engine result valid |
| mvm_res_idx_i | input | AW | Pixel or measurement index of the result |
| mvm_res_data_i | input | DW | Engine result value |
| mvm_done_i | input | 1 | Engine finished the current request |
| img_raddr_i | input | AW | Image read address (engine or host) |
| img_rdata_o | output | DW | Image pixel at img_raddr_i, combinational |

## Verification
A wrong phase or a wrong iteration counter shows up at the engine interface within one request. The count of request pulses and the alternation of transpose and forward requests diverge from the arithmetic reference as soon as the loop takes an extra update or skips one. A corrupted residual or a corrupted pixel update does not show until the run finishes. It then appears as one or more pixels that differ from the bench's fixed-point model, and those pixels are read back through the image port right after done rises. A faulty capture of the inputs or a start accepted while busy also changes the final image, so runs that change the inputs mid-flight are compared against the original values.

// File: rtl/ibp_pkg.sv
package ibp_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_INIT  = 3'd1,
        PH_FWD   = 3'd2,
        PH_CHECK = 3'd3,
        PH_BACK  = 3'd4,
        PH_DONE  = 3'd5
    } phase_e;
endpackage

// File: rtl/ibp_image_store.sv
module ibp_image_store #(
    parameter int NPIX = 256,
    parameter int DW   = 32,
    parameter int AW   = $clog2(NPIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] pix_q [NPIX];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPIX; i++) pix_q[i] <= '0;
        end else if (we) begin
            pix_q[waddr] <= wdata;
        end
    end

    assign rdata_a = pix_q[raddr_a];
    assign rdata_b = pix_q[raddr_b];
endmodule

// File: rtl/ibp_residual.sv
module ibp_residual #(
    parameter int NMEAS = 6,
    parameter int DW    = 32,
    parameter int AW    = 8
) (
    input  logic [NMEAS*DW-1:0] meas,
    input  logic [AW-1:0]       idx,
    input  logic [DW-1:0]       est,
    output logic [DW-1:0]       diff,
    output logic [DW-1:0]       mag,
    output logic                hit
);
    logic [DW-1:0] sel;

    always_comb begin
        sel = '0;
        hit = 1'b0;
        for (int i = 0; i < NMEAS; i++) begin
            if (idx == AW'(i)) begin
                sel = meas[i*DW +: DW];
                hit = 1'b1;
            end
        end
        diff = est - sel;
        mag  = diff[DW-1] ? (~diff + 1'b1) : diff;
    end
endmodule

// File: rtl/ibp_pixel_update.sv
module ibp_pixel_update #(
    parameter int DW   = 32,
    parameter int FRAC = 16
) (
    input  logic          init,
    input  logic [DW-1:0] old_pix,
    input  logic [DW-1:0] res,
    input  logic [DW-1:0] alpha,
    output logic [DW-1:0] pix
);
    localparam int WW = 2 * DW;
    localparam logic signed [WW-1:0] ONE_W = {{(WW-1){1'b0}}, 1'b1} << FRAC;

    logic signed [WW-1:0] prod;
    logic signed [WW-1:0] scaled;
    logic signed [WW-1:0] cand;
    logic signed [WW-1:0] res_w;
    logic signed [WW-1:0] old_w;

    always_comb begin
        res_w  = $signed({{DW{res[DW-1]}}, res});
        old_w  = $signed({{DW{old_pix[DW-1]}}, old_pix});
        prod   = $signed(alpha) * $signed(res);
        scaled = prod >>> FRAC;
        cand   = init ? res_w : (old_w - scaled);
        if (cand < 0)          pix = '0;
        else if (cand > ONE_W) pix = ONE_W[DW-1:0];
        else                   pix = cand[DW-1:0];
    end
endmodule

// File: rtl/ibp_recon_ctrl.sv
module ibp_recon_ctrl
    import ibp_pkg::*;
#(
    parameter int NMEAS = 6,
    parameter int NPIX  = 256,
    parameter int DW    = 32,
    parameter int FRAC  = 16,
    parameter int ITW   = 8,
    parameter int AW    = $clog2(NPIX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [NMEAS*DW-1:0] meas_i,
    input  logic [DW-1:0]       alpha_i,
    input  logic [ITW-1:0]      iter_limit_i,
    input  logic [DW-1:0]       thresh_i,
    output logic                done_o,
    output logic                mvm_start_o,
    output logic                mvm_fwd_o,
    output logic [NMEAS*DW-1:0] mvm_vec_o,
    input  logic                mvm_res_valid_i,
    input  logic [AW-1:0]       mvm_res_idx_i,
    input  logic [DW-1:0]       mvm_res_data_i,
    input  logic                mvm_done_i,
    input  logic [AW-1:0]       img_raddr_i,
    output logic [DW-1:0]       img_rdata_o
);
    localparam int VW = NMEAS * DW;

    typedef struct packed {
        phase_e         ph;
        logic           go;
        logic [ITW-1:0] iters;
        logic [DW-1:0]  maxres;
        logic [VW-1:0]  meas;
        logic [VW-1:0]  diff;
        logic [DW-1:0]  alpha;
        logic [ITW-1:0] limit;
        logic [DW-1:0]  thr;
    } ctl_t;

    ctl_t q, d;

    logic          busy;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] old_pix;
    logic [DW-1:0] res_diff;
    logic [DW-1:0] res_mag;
    logic          res_hit;
    logic [VW-1:0] meas_lat;

    assign meas_lat = q.meas;
    assign busy     = (q.ph != PH_IDLE) && (q.ph != PH_DONE);
    assign wr_en    = mvm_res_valid_i && ((q.ph == PH_INIT) || (q.ph == PH_BACK));

    ibp_image_store #(.NPIX(NPIX), .DW(DW), .AW(AW)) u_img (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (mvm_res_idx_i),
        .wdata   (wr_data),
        .raddr_a (img_raddr_i),
        .rdata_a (img_rdata_o),
        .raddr_b (mvm_res_idx_i),
        .rdata_b (old_pix)
    );

    ibp_residual #(.NMEAS(NMEAS), .DW(DW), .AW(AW)) u_res (
        .meas (q.meas),
        .idx  (mvm_res_idx_i),
        .est  (mvm_res_data_i),
        .diff (res_diff),
        .mag  (res_mag),
        .hit  (res_hit)
    );

    ibp_pixel_update #(.DW(DW), .FRAC(FRAC)) u_upd (
        .init    (q.ph == PH_INIT),
        .old_pix (old_pix),
        .res     (mvm_res_data_i),
        .alpha   (q.alpha),
        .pix     (wr_data)
    );

    always_comb begin
        d    = q;
        d.go = 1'b0;
        unique case (q.ph)
            PH_IDLE, PH_DONE: begin
                if (start_i) begin
                    d.ph    = PH_INIT;
                    d.go    = 1'b1;
                    d.iters = '0;
                    d.meas  = meas_i;
                    d.alpha = alpha_i;
                    d.limit = iter_limit_i;
                    d.thr   = thresh_i;
                end
            end
            PH_INIT: begin
                if (mvm_done_i) begin
                    d.ph     = PH_FWD;
                    d.go     = 1'b1;
                    d.maxres = '0;
                end
            end
            PH_FWD: begin
                if (mvm_res_valid_i && res_hit) begin
                    for (int i = 0; i < NMEAS; i++) begin
                        if (mvm_res_idx_i == AW'(i)) d.diff[i*DW +: DW] = res_diff;
                    end
                    if (res_mag > q.maxres) d.maxres = res_mag;
                end
                if (mvm_done_i) d.ph = PH_CHECK;
            end
            PH_CHECK: begin
                if ((q.maxres <= q.thr) || (q.iters == q.limit)) begin
                    d.ph = PH_DONE;
                end else begin
                    d.ph = PH_BACK;
                    d.go = 1'b1;
                end
            end
            PH_BACK: begin
                if (mvm_done_i) begin
                    d.ph     = PH_FWD;
                    d.go     = 1'b1;
                    d.iters  = q.iters + 1'b1;
                    d.maxres = '0;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o      = (q.ph == PH_DONE);
    assign mvm_start_o = q.go;
    assign mvm_fwd_o   = (q.ph == PH_FWD);
    assign mvm_vec_o   = (q.ph == PH_INIT) ? meas_lat : q.diff;
endmodule

// File: rtl/ibp_recon_chk.sv
module ibp_recon_chk #(
    parameter int DW   = 32,
    parameter int FRAC = 16,
    parameter int MW   = 192
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          done_o,
    input logic          mvm_start_o,
    input logic          mvm_fwd_o,
    input logic          mvm_done_i,
    input logic          busy,
    input logic          wr_en,
    input logic [DW-1:0] wr_data,
    input logic [MW-1:0] meas_lat
);
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1} << FRAC;

    logic pend_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (mvm_start_o) pend_q <= 1'b1;
        else if (mvm_done_i)  pend_q <= 1'b0;
    end

    // R1
    first_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> (mvm_start_o && !mvm_fwd_o));

    // R2
    fwd_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mvm_done_i && busy && !mvm_fwd_o) |=> (mvm_start_o && mvm_fwd_o));

    // R6
    pix_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!wr_data[DW-1] && (wr_data <= ONE)));

    // R7
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mvm_start_o |=> !mvm_start_o);

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mvm_start_o |-> !pend_q);

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i) |=> $stable(meas_lat));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R9
    done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (!done_o && mvm_start_o));
endmodule

bind ibp_recon_ctrl ibp_recon_chk #(.DW(DW), .FRAC(FRAC), .MW(NMEAS*DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .done_o      (done_o),
    .mvm_start_o (mvm_start_o),
    .mvm_fwd_o   (mvm_fwd_o),
    .mvm_done_i  (mvm_done_i),
    .busy        (busy),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .meas_lat    (meas_lat)
);

// File: tb/ibp_recon_ctrl_bench.sv
module ibp_recon_ctrl_bench;
    localparam int CLK_PERIOD = 100;
    localparam int NM  = 3;
    localparam int NP  = 16;
    localparam int DW  = 32;
    localparam int FR  = 16;
    localparam int ITW = 8;
    localparam int AW  = 4;
    localparam int ONE = 65536;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [NM*DW-1:0] meas_i = '0;
    logic [DW-1:0] alpha_i = '0;
    logic [ITW-1:0] iter_limit_i = '0;
    logic [DW-1:0] thresh_i = '0;
    logic done_o, mvm_start_o, mvm_fwd_o;
    logic [NM*DW-1:0] mvm_vec_o;
    logic eng_valid = 1'b0;
    logic [AW-1:0] eng_idx = '0;
    logic [DW-1:0] eng_data = '0;
    logic eng_done = 1'b0;
    logic [AW-1:0] raddr = '0;
    logic [DW-1:0] img_rdata_o;

    int checks = 0;
    int fails = 0;
    int req_n = 0;
    bit req_fwd [64];
    int first_vec [NM];
    int ref_img [NP];
    int ref_k;
    bit ref_by_thr;

    always #(CLK_PERIOD/2) clk = ~clk;

    ibp_recon_ctrl #(.NMEAS(NM), .NPIX(NP), .DW(DW), .FRAC(FR), .ITW(ITW), .AW(AW)) u_ibp_recon_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .meas_i(meas_i),
        .alpha_i(alpha_i), .iter_limit_i(iter_limit_i), .thresh_i(thresh_i),
        .done_o(done_o), .mvm_start_o(mvm_start_o), .mvm_fwd_o(mvm_fwd_o),
        .mvm_vec_o(mvm_vec_o), .mvm_res_valid_i(eng_valid), .mvm_res_idx_i(eng_idx),
        .mvm_res_data_i(eng_data), .mvm_done_i(eng_done),
        .img_raddr_i(raddr), .img_rdata_o(img_rdata_o)
    );

    function automatic longint sens(int i, int p);
        return longint'(((i * 5 + p * 3 + (i * p) % 4) % 9) + 1) * 2048;
    endfunction

    function automatic int bp(int v [NM], int p);
        longint s = 0;
        for (int i = 0; i < NM; i++) s += sens(i, p) * longint'(v[i]);
        return int'(s >>> FR);
    endfunction

    function automatic int fw(int im [NP], int i);
        longint s = 0;
        for (int p = 0; p < NP; p++) s += sens(i, p) * longint'(im[p]);
        return int'(s >>> FR);
    endfunction

    function automatic int sat1(longint x);
        if (x < 0) return 0;
        if (x > ONE) return ONE;
        return int'(x);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural multiply engine
    initial begin
        int v [NM];
        int im [NP];
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (mvm_start_o) begin
                for (int i = 0; i < NM; i++) v[i] = int'(mvm_vec_o[i*DW +: DW]);
                if (req_n < 64) req_fwd[req_n] = mvm_fwd_o;
                if (req_n == 0) for (int i = 0; i < NM; i++) first_vec[i] = v[i];
                req_n++;
                if (!mvm_fwd_o) begin
                    for (int p = 0; p < NP; p++) begin
                        @(negedge clk);
                        eng_valid = 1'b1; eng_idx = AW'(p); eng_data = bp(v, p);
                    end
                end else begin
                    for (int p = 0; p < NP; p++) begin
                        raddr = AW'(p); #1; im[p] = int'(img_rdata_o);
                    end
                    for (int i = 0; i < NM; i++) begin
                        @(negedge clk);
                        eng_valid = 1'b1; eng_idx = AW'(i); eng_data = fw(im, i);
                    end
                end
                @(negedge clk);
                eng_valid = 1'b0; eng_done = 1'b1;
            end
        end
    end

    task automatic ref_run(input int m [NM], input int alpha, input int limit, input int thr);
        int dv [NM];
        longint maxres;
        for (int p = 0; p < NP; p++) ref_img[p] = sat1(longint'(bp(m, p)));
        ref_k = 0;
        forever begin
            maxres = 0;
            for (int i = 0; i < NM; i++) begin
                dv[i] = fw(ref_img, i) - m[i];
                if ((dv[i] < 0 ? -longint'(dv[i]) : longint'(dv[i])) > maxres)
                    maxres = dv[i] < 0 ? -longint'(dv[i]) : longint'(dv[i]);
            end
            ref_by_thr = (maxres <= longint'(thr));
            if (ref_by_thr || ref_k == limit) break;
            for (int p = 0; p < NP; p++)
                ref_img[p] = sat1(longint'(ref_img[p]) -
                                  ((longint'(alpha) * longint'(bp(dv, p))) >>> FR));
            ref_k++;
        end
    endtask

    task automatic run(input int m0, input int m1, input int m2, input int alpha,
                       input int limit, input int thr, input bit poke);
        int m [NM];
        int cnt;
        bit seq_ok;
        m[0] = m0; m[1] = m1; m[2] = m2;
        @(negedge clk);
        for (int i = 0; i < NM; i++) meas_i[i*DW +: DW] = m[i];
        alpha_i = alpha; iter_limit_i = ITW'(limit); thresh_i = thr;
        req_n = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            meas_i = {NM{32'h0002_0000}}; alpha_i = 32'h0001_0000;
            iter_limit_i = 8'd0; thresh_i = 32'h7fff_ffff;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        cnt = 0;
        while (!done_o && cnt < 20000) begin @(negedge clk); cnt++; end
        ref_run(m, alpha, limit, thr);
        chk(done_o == 1'b1, "R9 done raised at end of run", done_o, 1);
        chk(req_n == 2 * ref_k + 2, ref_by_thr ? "R3 R7 request count (threshold stop)"
                                               : "R4 R7 request count (limit stop)",
            req_n, 2 * ref_k + 2);
        chk(req_fwd[0] == 1'b0 && first_vec[0] == m0 && first_vec[1] == m1 && first_vec[2] == m2,
            "R1 first request transpose with readings", first_vec[0], m0);
        seq_ok = 1'b1;
        for (int k = 1; k < req_n && k < 64; k++)
            if (req_fwd[k] != (k % 2 == 1)) seq_ok = 1'b0;
        chk(seq_ok, "R2 R5 forward/transpose alternation", seq_ok, 1);
        for (int p = 0; p < NP; p++) begin
            raddr = AW'(p); #1;
            chk(int'(img_rdata_o) == ref_img[p],
                ref_k == 0 ? "R1 R6 initial pixel" : "R5 R6 updated pixel",
                int'(img_rdata_o), ref_img[p]);
        end
        repeat (4) @(negedge clk);
        chk(done_o == 1'b1, "R9 done held while idle", done_o, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(done_o == 1'b0, "R10 done low after reset", done_o, 0);
        chk(mvm_start_o == 1'b0, "R10 no request after reset", mvm_start_o, 0);
        for (int p = 0; p < NP; p++) begin
            raddr = AW'(p); #1;
            chk(img_rdata_o == '0, "R10 pixel zero after reset", img_rdata_o, 0);
        end
        // R4 limit 0, R3 huge threshold
        run(32768, 19661, 52429, 32768, 0, 0, 1'b0);
        run(32768, 19661, 52429, 32768, 5, 32'h7fff_ffff, 1'b0);
        run(32768, 19661, 52429, 32768, 3, 0, 1'b0);
        // R6 saturation low and high
        run(-65536, -32768, -131072, 32768, 2, 0, 1'b0);
        run(262144, 196608, 327680, 65536, 2, 0, 1'b0);
        // R8 start while busy with changed inputs
        run(39322, 13107, 58982, 16384, 3, 0, 1'b1);
        // sweep limits and relaxation factors
        for (int lim = 0; lim < 5; lim++) begin
            for (int a = 0; a < 3; a++) begin
                run(39322, 13107, 58982, (a == 0) ? 16384 : (a == 1) ? 32768 : 65536,
                    lim, 3000, 1'b0);
            end
        end
        // R9 done falls one cycle after accepted start
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0, "R9 done falls after start", done_o, 0);
        begin
            int cnt = 0;
            while (!done_o && cnt < 20000) begin @(negedge clk); cnt++; end
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule